// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block supervises a low-power stop state. The main oscillator is halted in this state, while a slow watchdog on its own RC clock keeps counting. When a stop request arrives under the right control-bit pattern, the block turns off the oscillator enable and the CPU clock enable. It also raises a hold flag, which tells the surrounding logic to freeze control registers and port outputs. It then waits for a hardware reset, an external interrupt or a watchdog event.

After a wake-up by interrupt, the oscillator is switched back on. An 8-bit interval counter is cleared and counts prescaler ticks from 00h up to FFh. The tick after FFh overflows the counter, which marks the oscillator as settled and re-enables the CPU clock. On that same edge the block issues one outcome pulse: a vector request, with a selector naming external or watchdog, or a resume at the instruction after the stop. A watchdog event with the watchdog-reset bit set skips stabilization and pulses an internal reset instead.

Top module: `stopwake_seq`

## Requirements
- R1: The stop state is entered only when `stop_req` is 1 at a clock edge in idle while `cfg_wake`=0 and `cfg_rcwd`=1. Any other pattern leaves `osc_en`, `cpu_clk_en` and `hold_ctx` unchanged.
- R2: From the edge that accepts the stop request, `osc_en` and `cpu_clk_en` are 0 and `hold_ctx` is 1.
- R3: `hold_ctx` stays 1 through the whole stop and stabilization period. Prescaler ticks in the stop state do not move the counter.
- R4: Only `ext_irq` or `wd_evt` ends the stop state. On the waking edge `osc_en` returns to 1, `cpu_clk_en` stays 0 and the counter reads 00h.
- R5: During stabilization the counter advances by one on each cycle with `presc_tick`=1 and holds otherwise. After 255 ticks it reads FFh with the CPU clock still off. The 256th tick wraps it to 00h, sets `cpu_clk_en` to 1 and drops `hold_ctx`.
- R6: With `gie`=1 at the overflow edge, a wake-up caused by `ext_irq` gives a one-cycle `vec_req` with `vec_sel`=0 (external) on that edge.
- R7: With `gie`=1, a watchdog wake-up with `cfg_wdrst`=0 and `wd_ie`=1 gives a one-cycle `vec_req` with `vec_sel`=1 (watchdog).
- R8: A `wd_evt` in the stop state while `cfg_wdrst`=1 gives a one-cycle `int_rst` on the next edge, with no stabilization. The block returns to idle with both enables at 1. This takes priority over a simultaneous `ext_irq`.
- R9: With `gie`=0 at overflow, or a watchdog wake-up with `wd_ie`=0, the block gives a one-cycle `resume` and no `vec_req`.
- R10: `rst`=1 during stabilization aborts it. On that edge the counter reads 00h, both enables read 1, `hold_ctx` reads 0, and no outcome pulse follows.
- R11: When `ext_irq` and `wd_evt` arrive on the same edge with `cfg_wdrst`=0, the wake-up counts as external (`vec_sel`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| stop_req | input | 1 | Stop request from the core |
| cfg_wake | input | 1 | Wake-up mode control bit (must be 0) |
| cfg_rcwd | input | 1 | RC watchdog mode control bit (must be 1) |
| cfg_wdrst | input | 1 | Watchdog event causes internal reset when 1 |
| wd_ie | input | 1 | Watchdog interrupt enable |
| gie | input | 1 | Global interrupt-enable flag |
| ext_irq | input | 1 | External interrupt line |
| wd_evt | input | 1 | Watchdog event from the RC-clocked watchdog |
| presc_tick | input | 1 | Prescaler tick advancing the interval counter |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| hold_ctx | output | 1 | Freeze control registers and port outputs |
| stab_cnt | output | 8 | Interval counter value |
| vec_req | output | 1 | One-cycle interrupt vector request |
| vec_sel | output | 1 | Vector select: 0 external, 1 watchdog |
| int_rst | output | 1 | One-cycle internal reset |
| resume | output | 1 | One-cycle resume-after-stop pulse |

## Verification
Some properties are checked on every cycle. The CPU clock stays off whenever the oscillator is off or the counter is settling. The counter moves only on ticks. Outcome pulses are single and mutually exclusive, and they appear only at the end of a held period. Entry into hold happens only under the accepted control pattern. Other behaviour needs the directed scenarios: the exact 256-tick length, the choice between the external vector, the watchdog vector, resume and reset for each mix of `gie`, `wd_ie` and `cfg_wdrst`, the priority on simultaneous events, and the clean abort under reset.

// File: rtl/stopwake_pkg.sv
package stopwake_pkg;
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_STOP = 2'd1,
    SW_STAB = 2'd2
  } sw_state_t;
endpackage

// File: rtl/stopwake_ivc.sv
// Interval counter used as the oscillator settling timer.
module stopwake_ivc #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  assign ovf = en && tick && (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/stopwake_fsm.sv
// Stop/stabilize/idle sequencing and clock gating.
module stopwake_fsm
  import stopwake_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      stop_req,
  input  logic      cfg_wake,
  input  logic      cfg_rcwd,
  input  logic      cfg_wdrst,
  input  logic      ext_irq,
  input  logic      wd_evt,
  input  logic      ovf,
  output sw_state_t state,
  output logic      cnt_clr,
  output logic      cnt_en,
  output logic      src_wd,
  output logic      wd_rst_fire,
  output logic      stab_done,
  output logic      osc_en,
  output logic      cpu_clk_en,
  output logic      hold_ctx
);
  sw_state_t nxt;
  logic      enter;
  logic      wake;

  always_comb begin
    enter       = (state == SW_IDLE) && stop_req && !cfg_wake && cfg_rcwd;
    wd_rst_fire = (state == SW_STOP) && wd_evt && cfg_wdrst;
    wake        = (state == SW_STOP) && !wd_rst_fire && (ext_irq || wd_evt);
    cnt_clr     = wake;
    cnt_en      = (state == SW_STAB);
    stab_done   = (state == SW_STAB) && ovf;
    nxt         = state;
    unique case (state)
      SW_IDLE: if (enter) nxt = SW_STOP;
      SW_STOP: begin
        if (wd_rst_fire)  nxt = SW_IDLE;
        else if (wake)    nxt = SW_STAB;
      end
      SW_STAB: if (ovf) nxt = SW_IDLE;
      default: nxt = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SW_IDLE;
      src_wd     <= 1'b0;
      osc_en     <= 1'b1;
      cpu_clk_en <= 1'b1;
      hold_ctx   <= 1'b0;
    end else begin
      state      <= nxt;
      if (wake) src_wd <= !ext_irq;
      osc_en     <= (nxt != SW_STOP);
      cpu_clk_en <= (nxt == SW_IDLE);
      hold_ctx   <= (nxt != SW_IDLE);
    end
  end
endmodule

// File: rtl/stopwake_outcome.sv
// Registered one-cycle outcome pulses.
module stopwake_outcome (
  input  logic clk,
  input  logic rst,
  input  logic stab_done,
  input  logic wd_rst_fire,
  input  logic src_wd,
  input  logic gie,
  input  logic wd_ie,
  output logic vec_req,
  output logic vec_sel,
  output logic int_rst,
  output logic resume
);
  logic vector_ok;
  assign vector_ok = gie && (!src_wd || wd_ie);

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_req <= 1'b0;
      vec_sel <= 1'b0;
      int_rst <= 1'b0;
      resume  <= 1'b0;
    end else begin
      int_rst <= wd_rst_fire;
      vec_req <= stab_done && vector_ok;
      vec_sel <= stab_done && vector_ok && src_wd;
      resume  <= stab_done && !vector_ok;
    end
  end
endmodule

// File: rtl/stopwake_seq.sv
module stopwake_seq
  import stopwake_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stop_req,
  input  logic             cfg_wake,
  input  logic             cfg_rcwd,
  input  logic             cfg_wdrst,
  input  logic             wd_ie,
  input  logic             gie,
  input  logic             ext_irq,
  input  logic             wd_evt,
  input  logic             presc_tick,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             hold_ctx,
  output logic [CNT_W-1:0] stab_cnt,
  output logic             vec_req,
  output logic             vec_sel,
  output logic             int_rst,
  output logic             resume
);
  sw_state_t state;
  logic cnt_clr, cnt_en, ovf, src_wd, wd_rst_fire, stab_done;

  stopwake_fsm u_fsm (
    .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_wake(cfg_wake),
    .cfg_rcwd(cfg_rcwd), .cfg_wdrst(cfg_wdrst), .ext_irq(ext_irq),
    .wd_evt(wd_evt), .ovf(ovf), .state(state), .cnt_clr(cnt_clr),
    .cnt_en(cnt_en), .src_wd(src_wd), .wd_rst_fire(wd_rst_fire),
    .stab_done(stab_done), .osc_en(osc_en), .cpu_clk_en(cpu_clk_en),
    .hold_ctx(hold_ctx)
  );

  stopwake_ivc #(.CNT_W(CNT_W)) u_ivc (
    .clk(clk), .rst(rst), .clr(cnt_clr), .en(cnt_en),
    .tick(presc_tick), .cnt(stab_cnt), .ovf(ovf)
  );

  stopwake_outcome u_out (
    .clk(clk), .rst(rst), .stab_done(stab_done), .wd_rst_fire(wd_rst_fire),
    .src_wd(src_wd), .gie(gie), .wd_ie(wd_ie), .vec_req(vec_req),
    .vec_sel(vec_sel), .int_rst(int_rst), .resume(resume)
  );
endmodule

// File: rtl/stopwake_chk.sv
module stopwake_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             stop_req,
  input logic             cfg_wake,
  input logic             cfg_rcwd,
  input logic             presc_tick,
  input logic             osc_en,
  input logic             cpu_clk_en,
  input logic             hold_ctx,
  input logic [CNT_W-1:0] stab_cnt,
  input logic             vec_req,
  input logic             int_rst,
  input logic             resume
);
  // R1: hold only starts after an accepted request pattern
  a_r1_entry_pattern: assert property (@(posedge clk) disable iff (rst)
    $rose(hold_ctx) |-> $past(stop_req && !cfg_wake && cfg_rcwd));

  // R2: oscillator off implies CPU clock off and context held
  a_r2_gated: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!cpu_clk_en && hold_ctx));

  // R5: CPU clock stays off while settling
  a_r5_cpu_held: assert property (@(posedge clk) disable iff (rst)
    (hold_ctx && osc_en) |-> !cpu_clk_en);

  // R5: counter moves only on ticks while settling
  a_r5_count_hold: assert property (@(posedge clk) disable iff (rst)
    (hold_ctx && osc_en && !presc_tick) |=> $stable(stab_cnt));

  // R6: vector pulse is single-cycle and follows a held period
  a_r6_vec_single: assert property (@(posedge clk) disable iff (rst)
    vec_req |=> !vec_req);
  a_r6_vec_after_hold: assert property (@(posedge clk) disable iff (rst)
    vec_req |-> ($past(hold_ctx) && !hold_ctx));

  // R8: internal reset is a single pulse
  a_r8_rst_single: assert property (@(posedge clk) disable iff (rst)
    int_rst |=> !int_rst);

  // R9: outcome pulses never overlap
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({vec_req, int_rst, resume}) <= 1);
endmodule

bind stopwake_seq stopwake_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_wake(cfg_wake),
  .cfg_rcwd(cfg_rcwd), .presc_tick(presc_tick), .osc_en(osc_en),
  .cpu_clk_en(cpu_clk_en), .hold_ctx(hold_ctx), .stab_cnt(stab_cnt),
  .vec_req(vec_req), .int_rst(int_rst), .resume(resume)
);

// File: tb/sim_stopwake_seq.sv
`timescale 1ns/1ps
module sim_stopwake_seq;
  logic clk = 1'b0;
  logic rst, stop_req, cfg_wake, cfg_rcwd, cfg_wdrst, wd_ie, gie;
  logic ext_irq, wd_evt, presc_tick;
  logic osc_en, cpu_clk_en, hold_ctx, vec_req, vec_sel, int_rst, resume;
  logic [7:0] stab_cnt;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stopwake_seq u0 (
    .clk(clk), .rst(rst), .stop_req(stop_req), .cfg_wake(cfg_wake),
    .cfg_rcwd(cfg_rcwd), .cfg_wdrst(cfg_wdrst), .wd_ie(wd_ie), .gie(gie),
    .ext_irq(ext_irq), .wd_evt(wd_evt), .presc_tick(presc_tick),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .hold_ctx(hold_ctx),
    .stab_cnt(stab_cnt), .vec_req(vec_req), .vec_sel(vec_sel),
    .int_rst(int_rst), .resume(resume)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    stop_req = 0; ext_irq = 0; wd_evt = 0; presc_tick = 0;
  endtask

  task automatic do_reset();
    idle_inputs();
    rst = 1; step(); step(); rst = 0;
  endtask

  task automatic enter_stop();
    cfg_wake = 0; cfg_rcwd = 1;
    stop_req = 1; step(); stop_req = 0;
  endtask

  // 255 ticks, then the final overflow tick; gap idle cycles after each tick
  task automatic settle(input int gap);
    for (int i = 0; i < 255; i++) begin
      presc_tick = 1; step(); presc_tick = 0;
      for (int g = 0; g < gap; g++) step();
    end
    chk("R5 count at FFh", stab_cnt, 255);
    chk("R5 cpu still off", cpu_clk_en, 0);
    presc_tick = 1; step(); presc_tick = 0;
    chk("R5 wrap to 00h", stab_cnt, 0);
    chk("R5 cpu back on", cpu_clk_en, 1);
    chk("R5 hold released", hold_ctx, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 reset osc_en", osc_en, 1);
    chk("R1 reset cpu_clk_en", cpu_clk_en, 1);
    chk("R1 reset hold", hold_ctx, 0);
    chk("R1 reset pulses", {vec_req, int_rst, resume}, 0);
  endtask

  task automatic t_bad_pattern();
    cfg_wake = 1; cfg_rcwd = 1; stop_req = 1; step(); stop_req = 0;
    chk("R1 pattern 11 ignored", {osc_en, cpu_clk_en, hold_ctx}, 6);
    cfg_wake = 0; cfg_rcwd = 0; stop_req = 1; step(); stop_req = 0;
    chk("R1 pattern 00 ignored", {osc_en, cpu_clk_en, hold_ctx}, 6);
    cfg_wake = 1; cfg_rcwd = 0; stop_req = 1; step(); stop_req = 0;
    chk("R1 pattern 10 ignored", {osc_en, cpu_clk_en, hold_ctx}, 6);
  endtask

  task automatic t_ext_vector();
    gie = 1; wd_ie = 1; cfg_wdrst = 0;
    enter_stop();
    chk("R2 osc off", osc_en, 0);
    chk("R2 cpu off", cpu_clk_en, 0);
    chk("R2 hold on", hold_ctx, 1);
    presc_tick = 1; step(); presc_tick = 0;
    chk("R3 tick ignored in stop", stab_cnt, 0);
    chk("R3 hold kept", hold_ctx, 1);
    chk("R4 still stopped", osc_en, 0);
    ext_irq = 1; step(); ext_irq = 0;
    chk("R4 osc on at wake", osc_en, 1);
    chk("R4 cpu off at wake", cpu_clk_en, 0);
    chk("R4 count cleared", stab_cnt, 0);
    presc_tick = 1; step(); presc_tick = 0; step(); step();
    chk("R5 one tick one step", stab_cnt, 1);
    for (int i = 0; i < 253; i++) begin presc_tick = 1; step(); end
    presc_tick = 0;
    chk("R5 at 254", stab_cnt, 254);
    presc_tick = 1; step(); presc_tick = 0;
    chk("R3 hold during stab", hold_ctx, 1);
    presc_tick = 1; step(); presc_tick = 0;
    chk("R6 vec_req", vec_req, 1);
    chk("R6 vec_sel external", vec_sel, 0);
    chk("R6 no resume", resume, 0);
    step();
    chk("R6 vec_req one cycle", vec_req, 0);
  endtask

  task automatic t_wd_vector();
    gie = 1; wd_ie = 1; cfg_wdrst = 0;
    enter_stop();
    wd_evt = 1; step(); wd_evt = 0;
    chk("R7 no int_rst", int_rst, 0);
    settle(1);
    chk("R7 vec_req", vec_req, 1);
    chk("R7 vec_sel watchdog", vec_sel, 1);
    step();
    chk("R7 pulse ends", vec_req, 0);
  endtask

  task automatic t_wd_reset();
    gie = 1; wd_ie = 1; cfg_wdrst = 1;
    enter_stop();
    wd_evt = 1; ext_irq = 1; step(); wd_evt = 0; ext_irq = 0;
    chk("R8 int_rst", int_rst, 1);
    chk("R8 no vector", vec_req, 0);
    chk("R8 back to idle", {osc_en, cpu_clk_en, hold_ctx}, 6);
    step();
    chk("R8 int_rst one cycle", int_rst, 0);
    cfg_wdrst = 0;
  endtask

  task automatic t_resume();
    gie = 0; wd_ie = 1; cfg_wdrst = 0;
    enter_stop();
    ext_irq = 1; step(); ext_irq = 0;
    settle(0);
    chk("R9 resume gie0", resume, 1);
    chk("R9 no vec gie0", vec_req, 0);
    step();
    chk("R9 resume one cycle", resume, 0);
    gie = 1; wd_ie = 0;
    enter_stop();
    wd_evt = 1; step(); wd_evt = 0;
    settle(0);
    chk("R9 resume wd_ie0", resume, 1);
    chk("R9 no vec wd_ie0", vec_req, 0);
    wd_ie = 1;
  endtask

  task automatic t_abort();
    gie = 1; wd_ie = 1; cfg_wdrst = 0;
    enter_stop();
    ext_irq = 1; step(); ext_irq = 0;
    for (int i = 0; i < 10; i++) begin presc_tick = 1; step(); end
    presc_tick = 0;
    chk("R10 counted before abort", stab_cnt, 10);
    rst = 1; step(); rst = 0;
    chk("R10 count zero", stab_cnt, 0);
    chk("R10 enables on", {osc_en, cpu_clk_en, hold_ctx}, 6);
    for (int i = 0; i < 300; i++) begin presc_tick = 1; step(); end
    presc_tick = 0;
    chk("R10 no pulse afterwards", {vec_req, int_rst, resume}, 0);
    chk("R10 counter idle", stab_cnt, 0);
  endtask

  task automatic t_simultaneous();
    gie = 1; wd_ie = 1; cfg_wdrst = 0;
    enter_stop();
    ext_irq = 1; wd_evt = 1; step(); ext_irq = 0; wd_evt = 0;
    settle(0);
    chk("R11 vec_req", vec_req, 1);
    chk("R11 external wins", vec_sel, 0);
    step();
  endtask

  initial begin
    rst = 1; cfg_wake = 0; cfg_rcwd = 0; cfg_wdrst = 0; wd_ie = 0; gie = 0;
    idle_inputs();
    t_reset_state();
    t_bad_pattern();
    t_ext_vector();
    t_wd_vector();
    t_wd_reset();
    t_resume();
    t_abort();
    t_simultaneous();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule